// File: doc/BRIEF.md
# Receive Session Open/Close Sequencer

This block keeps track of up to four receive sessions for a UDP receiver. The user drives a per-session enable vector. The block answers with an active vector that follows the enables, one session at a time. A settings bank goes with it. The shared settings are the operating mode, the station's own MAC address and its own IP address. Each session also has a multicast group IP, a local port, a remote IP and a remote port. Each item is captured at the moment its enable rises and held steady for the receive datapath.

In multicast mode each open or close goes through a message generator on the transmit side. The block raises a request that carries the session index and a join/leave flag, holds it, and waits for a one-cycle done pulse before it updates the active bit. In unicast mode no message goes out: the session's state is initialised or cleared internally and the active bit follows one cycle later. The sequence has settled when the active vector equals the registered enable vector.

Top module: `sess_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sess_act` is 0000 and `msg_req` is low.
- R2: `mcast_mode`, `own_mac` and `own_ip` take their inputs only at the edge where the enable vector goes from all zeros to non-zero while every session is inactive and no operation runs. At all other times the mode, MAC and IP inputs are ignored.
- R3: A session's parameters are captured at the edge where its enable bit rises, if that session is inactive and is not the one being worked on. They do not change while the session's active bit is set. Session i occupies bits [i*W +: W] of each flat parameter port.
- R4: Pending sessions (registered enable differs from active) are handled one at a time, lowest index first. At most one active bit changes per cycle.
- R5: In multicast mode an open raises `msg_req` with `msg_idx` = session index and `msg_leave` = 0. The request stays stable until `msg_done` is seen, and the active bit is set at that edge and not before.
- R6: In multicast mode a close raises `msg_req` with `msg_leave` = 1. The active bit is cleared at the `msg_done` edge and not before.
- R7: In unicast mode `msg_req` never rises. An enable change is seen at the next edge, the session is picked at the edge after, and its active bit changes at the third edge.
- R8: If a session's enable toggles while its own operation is pending or running, that operation finishes first. The session is then handled again with the parameters it already holds.
- R9: Once the inputs are quiet, the sequence ends with `sess_act` equal to the enable vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sess_en | input | 4 | Per-session enable from the user |
| mode_in | input | 1 | Mode select: 1 multicast, 0 unicast |
| own_mac_in | input | 48 | Own MAC address |
| own_ip_in | input | 32 | Own IP address |
| grp_ip_in | input | 128 | Multicast group IP per session |
| lport_in | input | 64 | Local UDP port per session |
| rip_in | input | 128 | Remote IP per session |
| rport_in | input | 64 | Remote UDP port per session |
| msg_done | input | 1 | One-cycle completion pulse from the message generator |
| sess_act | output | 4 | Per-session active status |
| msg_req | output | 1 | Message request, held until done |
| msg_idx | output | 2 | Session index of the request |
| msg_leave | output | 1 | 1 leave-group, 0 join (membership report) |
| mcast_mode | output | 1 | Latched mode |
| own_mac | output | 48 | Latched own MAC |
| own_ip | output | 32 | Latched own IP |
| grp_ip | output | 128 | Latched group IPs |
| lport | output | 64 | Latched local ports |
| rip | output | 128 | Latched remote IPs |
| rport | output | 64 | Latched remote ports |

## Verification
The bench uses the default build: four sessions, a 2-bit index, and 48/32/16-bit address and port fields. With that size it can open sessions 0 and 2, which leaves a gap, and then add session 3, the highest index. This exercises the lowest-first pick across gaps and at the top of the vector. Unicast tests on sessions 1 and 3 check the exact cycle at which each active bit changes, and a toggle of session 1 during its own close. A closing all-zero phase lets the mode be changed from unicast back to multicast.

// File: rtl/sess_seq_pkg.sv
package sess_seq_pkg;
    localparam int N_SESS = 4;
    localparam int IDX_W  = (N_SESS > 1) ? $clog2(N_SESS) : 1;
    localparam int MAC_W  = 48;
    localparam int IP_W   = 32;
    localparam int PORT_W = 16;

    typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_LOCAL} op_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             opening;
    } op_t;

    function automatic logic [IDX_W-1:0] first_set(input logic [N_SESS-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = N_SESS - 1; i >= 0; i--)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/sess_op_fsm.sv
module sess_op_fsm
    import sess_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SESS-1:0] en_q,
    input  logic              mcast,
    input  logic              done,
    output logic [N_SESS-1:0] act,
    output logic              busy,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              req,
    output logic              leave
);
    op_state_t         st;
    op_t               op;
    logic [N_SESS-1:0] pending;
    logic [IDX_W-1:0]  pick;

    assign pending = en_q ^ act;
    assign pick    = first_set(pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            act <= '0;
            op  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (|pending) begin
                    op.idx     <= pick;
                    op.opening <= en_q[pick];
                    st         <= mcast ? ST_MSG : ST_LOCAL;
                end
                ST_MSG: if (done) begin
                    act[op.idx] <= op.opening;
                    st          <= ST_IDLE;
                end
                ST_LOCAL: begin
                    act[op.idx] <= op.opening;
                    st          <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req     = (st == ST_MSG);
    assign leave   = ~op.opening;
    assign busy    = (st != ST_IDLE);
    assign cur_idx = op.idx;

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (act == '0) && !req);
    p_one_change_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(act ^ $past(act)) <= 1);
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req && !done) |=> req && $stable(cur_idx) && $stable(leave));
    p_mcast_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (mcast && !(req && done)) |=> $stable(act));
    p_no_msg_unicast_r7: assert property (@(posedge clk) disable iff (rst)
        !mcast |-> !req);
endmodule

// File: rtl/sess_param_store.sv
module sess_param_store
    import sess_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SESS-1:0]        en,
    input  logic [N_SESS-1:0]        en_q,
    input  logic [N_SESS-1:0]        act,
    input  logic                     busy,
    input  logic [IDX_W-1:0]         cur_idx,
    input  logic                     mode_in,
    input  logic [MAC_W-1:0]         mac_in,
    input  logic [IP_W-1:0]          ip_in,
    input  logic [N_SESS*IP_W-1:0]   grp_in,
    input  logic [N_SESS*PORT_W-1:0] lport_in,
    input  logic [N_SESS*IP_W-1:0]   rip_in,
    input  logic [N_SESS*PORT_W-1:0] rport_in,
    output logic                     mode_q,
    output logic [MAC_W-1:0]         mac_q,
    output logic [IP_W-1:0]          ip_q,
    output logic [N_SESS*IP_W-1:0]   grp_q,
    output logic [N_SESS*PORT_W-1:0] lport_q,
    output logic [N_SESS*IP_W-1:0]   rip_q,
    output logic [N_SESS*PORT_W-1:0] rport_q
);
    logic common_load;
    assign common_load = (en_q == '0) && (en != '0) && (act == '0) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            mac_q  <= '0;
            ip_q   <= '0;
        end else if (common_load) begin
            mode_q <= mode_in;
            mac_q  <= mac_in;
            ip_q   <= ip_in;
        end
    end

    p_common_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (en_q != '0) |=> $stable(mode_q) && $stable(mac_q) && $stable(ip_q));

    for (genvar i = 0; i < N_SESS; i++) begin : g_sess
        logic load;
        assign load = en[i] && !en_q[i] && !act[i] && !(busy && (cur_idx == IDX_W'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                grp_q[i*IP_W +: IP_W]       <= '0;
                lport_q[i*PORT_W +: PORT_W] <= '0;
                rip_q[i*IP_W +: IP_W]       <= '0;
                rport_q[i*PORT_W +: PORT_W] <= '0;
            end else if (load) begin
                grp_q[i*IP_W +: IP_W]       <= grp_in[i*IP_W +: IP_W];
                lport_q[i*PORT_W +: PORT_W] <= lport_in[i*PORT_W +: PORT_W];
                rip_q[i*IP_W +: IP_W]       <= rip_in[i*IP_W +: IP_W];
                rport_q[i*PORT_W +: PORT_W] <= rport_in[i*PORT_W +: PORT_W];
            end
        end

        p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
            act[i] |=> $stable(grp_q[i*IP_W +: IP_W]) && $stable(lport_q[i*PORT_W +: PORT_W])
                       && $stable(rip_q[i*IP_W +: IP_W]) && $stable(rport_q[i*PORT_W +: PORT_W]));
    end
endmodule

// File: rtl/sess_seq.sv
module sess_seq
    import sess_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SESS-1:0]        sess_en,
    input  logic                     mode_in,
    input  logic [MAC_W-1:0]         own_mac_in,
    input  logic [IP_W-1:0]          own_ip_in,
    input  logic [N_SESS*IP_W-1:0]   grp_ip_in,
    input  logic [N_SESS*PORT_W-1:0] lport_in,
    input  logic [N_SESS*IP_W-1:0]   rip_in,
    input  logic [N_SESS*PORT_W-1:0] rport_in,
    input  logic                     msg_done,
    output logic [N_SESS-1:0]        sess_act,
    output logic                     msg_req,
    output logic [IDX_W-1:0]         msg_idx,
    output logic                     msg_leave,
    output logic                     mcast_mode,
    output logic [MAC_W-1:0]         own_mac,
    output logic [IP_W-1:0]          own_ip,
    output logic [N_SESS*IP_W-1:0]   grp_ip,
    output logic [N_SESS*PORT_W-1:0] lport,
    output logic [N_SESS*IP_W-1:0]   rip,
    output logic [N_SESS*PORT_W-1:0] rport
);
    logic [N_SESS-1:0] en_q;
    logic              busy;

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= sess_en;
    end

    sess_op_fsm u_fsm (
        .clk(clk), .rst(rst), .en_q(en_q), .mcast(mcast_mode), .done(msg_done),
        .act(sess_act), .busy(busy), .cur_idx(msg_idx), .req(msg_req), .leave(msg_leave)
    );

    sess_param_store u_store (
        .clk(clk), .rst(rst), .en(sess_en), .en_q(en_q), .act(sess_act),
        .busy(busy), .cur_idx(msg_idx), .mode_in(mode_in), .mac_in(own_mac_in),
        .ip_in(own_ip_in), .grp_in(grp_ip_in), .lport_in(lport_in), .rip_in(rip_in),
        .rport_in(rport_in), .mode_q(mcast_mode), .mac_q(own_mac), .ip_q(own_ip),
        .grp_q(grp_ip), .lport_q(lport), .rip_q(rip), .rport_q(rport)
    );

    p_settle_r9: assert property (@(posedge clk) disable iff (rst)
        (sess_act != en_q) && $stable(en_q) && !msg_req |=> (sess_act != $past(sess_act)) || busy);
endmodule

// File: tb/sess_seq_test.sv
module sess_seq_test;
    import sess_seq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_SESS-1:0]        sess_en = '0;
    logic                     mode_in = 1'b0;
    logic [MAC_W-1:0]         own_mac_in = '0;
    logic [IP_W-1:0]          own_ip_in = '0;
    logic [N_SESS*IP_W-1:0]   grp_ip_in = '0;
    logic [N_SESS*PORT_W-1:0] lport_in = '0;
    logic [N_SESS*IP_W-1:0]   rip_in = '0;
    logic [N_SESS*PORT_W-1:0] rport_in = '0;
    logic                     msg_done = 1'b0;
    logic [N_SESS-1:0]        sess_act;
    logic                     msg_req;
    logic [IDX_W-1:0]         msg_idx;
    logic                     msg_leave;
    logic                     mcast_mode;
    logic [MAC_W-1:0]         own_mac;
    logic [IP_W-1:0]          own_ip;
    logic [N_SESS*IP_W-1:0]   grp_ip;
    logic [N_SESS*PORT_W-1:0] lport;
    logic [N_SESS*IP_W-1:0]   rip;
    logic [N_SESS*PORT_W-1:0] rport;

    int errors = 0;
    int checks = 0;
    op_t expq[$];

    always #2 clk = ~clk;

    sess_seq uut (.*);

    task automatic chk(input logic ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wait_act(input logic [N_SESS-1:0] tgt, input string tag);
        for (int n = 0; n < 200 && sess_act != tgt; n++) @(negedge clk);
        chk(sess_act == tgt, tag, 64'(sess_act), 64'(tgt));
    endtask

    task automatic push(input int idx, input logic leave);
        op_t e;
        e.idx = IDX_W'(idx);
        e.opening = ~leave;
        expq.push_back(e);
    endtask

    // monitor and message-generator model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && msg_req) begin
                op_t e;
                logic [IDX_W-1:0] ix;
                logic lv;
                ix = msg_idx;
                lv = msg_leave;
                if (expq.size() == 0) begin
                    chk(1'b0, "R7 unexpected request", 64'(ix), 64'hff);
                end else begin
                    e = expq.pop_front();
                    chk(ix == e.idx, "R4 request index", 64'(ix), 64'(e.idx));
                    chk(lv == ~e.opening, "R5/R6 join-leave flag", 64'(lv), 64'(~e.opening));
                    chk(sess_act[ix] == lv, "R5/R6 active before done", 64'(sess_act[ix]), 64'(lv));
                end
                @(negedge clk);
                chk(msg_req && msg_idx == ix, "R5 request held", 64'(msg_req), 64'h1);
                @(negedge clk);
                msg_done = 1'b1;
                @(negedge clk);
                msg_done = 1'b0;
                chk(sess_act[ix] == ~lv, "R5/R6 active after done", 64'(sess_act[ix]), 64'(~lv));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sess_act == '0, "R1 reset active", 64'(sess_act), 64'h0);
        chk(!msg_req, "R1 reset request", 64'(msg_req), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(sess_act == '0 && !msg_req, "R1 after reset", 64'(sess_act), 64'h0);

        // multicast open of sessions 0 and 2
        mode_in = 1'b1;
        own_mac_in = 48'h0A1B2C3D4E5F;
        own_ip_in = 32'hC0A80107;
        for (int i = 0; i < N_SESS; i++) begin
            grp_ip_in[i*IP_W +: IP_W] = 32'hE0000010 + i;
            lport_in[i*PORT_W +: PORT_W] = 16'h1000 + 16'(i);
            rip_in[i*IP_W +: IP_W] = 32'h0A000020 + i;
            rport_in[i*PORT_W +: PORT_W] = 16'h2000 + 16'(i);
        end
        push(0, 1'b0);
        push(2, 1'b0);
        sess_en = 4'b0101;
        wait_act(4'b0101, "R9 multicast open settles");
        chk(expq.size() == 0, "R4 all joins issued", 64'(expq.size()), 64'h0);
        chk(mcast_mode == 1'b1 && own_mac == 48'h0A1B2C3D4E5F && own_ip == 32'hC0A80107,
            "R2 common captured", 64'(own_ip), 64'hC0A80107);
        chk(grp_ip[0 +: IP_W] == 32'hE0000010, "R3 group ip s0", 64'(grp_ip[0 +: IP_W]), 64'hE0000010);
        chk(grp_ip[2*IP_W +: IP_W] == 32'hE0000012, "R3 group ip s2", 64'(grp_ip[2*IP_W +: IP_W]), 64'hE0000012);

        // inputs changed while active: must be ignored
        mode_in = 1'b0;
        own_ip_in = 32'h11111111;
        lport_in[0 +: PORT_W] = 16'hBEEF;
        repeat (5) @(negedge clk);
        chk(mcast_mode == 1'b1, "R2 mode ignored while enabled", 64'(mcast_mode), 64'h1);
        chk(own_ip == 32'hC0A80107, "R2 ip ignored while enabled", 64'(own_ip), 64'hC0A80107);
        chk(lport[0 +: PORT_W] == 16'h1000, "R3 frozen while active", 64'(lport[0 +: PORT_W]), 64'h1000);

        // add the highest session
        push(3, 1'b0);
        sess_en = 4'b1101;
        wait_act(4'b1101, "R5 session 3 joined");

        // close all, lowest first
        push(0, 1'b1);
        push(2, 1'b1);
        push(3, 1'b1);
        sess_en = 4'b0000;
        wait_act(4'b0000, "R6 multicast close settles");
        chk(expq.size() == 0, "R6 all leaves issued", 64'(expq.size()), 64'h0);

        // unicast: exact timing, no messages
        repeat (2) @(negedge clk);
        mode_in = 1'b0;
        lport_in[1*PORT_W +: PORT_W] = 16'h1111;
        sess_en = 4'b1010;
        @(negedge clk); chk(sess_act == 4'b0000, "R7 edge1", 64'(sess_act), 64'h0);
        @(negedge clk); chk(sess_act == 4'b0000, "R7 edge2", 64'(sess_act), 64'h0);
        @(negedge clk); chk(sess_act == 4'b0010, "R7 edge3 s1", 64'(sess_act), 64'h2);
        @(negedge clk); chk(sess_act == 4'b0010, "R4 s3 waits", 64'(sess_act), 64'h2);
        @(negedge clk); chk(sess_act == 4'b1010, "R4 s3 after s1", 64'(sess_act), 64'hA);
        chk(mcast_mode == 1'b0, "R2 unicast mode latched", 64'(mcast_mode), 64'h0);

        // toggle session 1 during its own close
        sess_en = 4'b1000;
        @(negedge clk);
        @(negedge clk);
        sess_en = 4'b1010;
        lport_in[1*PORT_W +: PORT_W] = 16'h7777;
        @(negedge clk); chk(sess_act == 4'b1000, "R8 close completes first", 64'(sess_act), 64'h8);
        @(negedge clk);
        @(negedge clk); chk(sess_act == 4'b1010, "R8 reopened", 64'(sess_act), 64'hA);
        chk(lport[1*PORT_W +: PORT_W] == 16'h1111, "R8 keeps held parameters",
            64'(lport[1*PORT_W +: PORT_W]), 64'h1111);

        // back to multicast after an all-zero phase
        sess_en = 4'b0000;
        wait_act(4'b0000, "R7 unicast close");
        repeat (2) @(negedge clk);
        mode_in = 1'b1;
        push(1, 1'b0);
        sess_en = 4'b0010;
        wait_act(4'b0010, "R9 reopen multicast");
        chk(mcast_mode == 1'b1, "R2 mode changed after all-zero", 64'(mcast_mode), 64'h1);
        chk(expq.size() == 0, "R5 join for session 1", 64'(expq.size()), 64'h0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule